// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is one bank of general-purpose I/O pins behind a simple 32-bit register bus with one-cycle writes and combinational reads. Software sees the synchronised pin levels, picks each pin's direction, and drives output values through write-only set and clear ports. Each pin can flag rising edges, falling edges or both. Flagged edges are held in a write-one-to-clear status register. A separate per-pin enable register gates the status bits into a single level-sensitive interrupt line.

Every control field apart from the interrupt enable can be changed atomically per bit. A set port writes ones into chosen bits and a clear port writes zeros into chosen bits, so no read-modify-write sequence is needed. The output value exists only through its set and clear ports. Direction and the two edge-enable fields also have a direct read/write address. Pin inputs pass through a two-flop synchroniser before they reach the level register and the edge detectors.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register is zero. `pin_oe_o`, `pin_o` and `irq_o` are low, and reads of the direction (0x0c), rising-enable (0x30), falling-enable (0x3c), status (0x48) and interrupt-enable (0x9c) addresses return zero.
- R2: Address 0x00 returns the pin inputs, whatever the pin direction. A change on `pin_i` appears in the read two clock edges later, not one.
- R3: A write to 0x18 sets the `pin_o` bits that are 1 in the write data. A write to 0x24 clears them. Bits written as 0 keep their value. `pin_o` follows on the edge of the write.
- R4: Direction reads and writes directly at 0x0c. Writing to 0x54 sets the bits that are 1 in the data, and writing to 0x60 clears them. A direction bit of 1 drives the matching `pin_oe_o` bit high, making the pin an output.
- R5: Rising enable reads and writes directly at 0x30, is set through 0x6c and cleared through 0x78. Falling enable does the same at 0x3c, with set at 0x84 and clear at 0x90. In each case only bits written as 1 change.
- R6: A status bit is set on the third clock edge after its pin changes. It is set for a 0-to-1 change when rising detection is on, for a 1-to-0 change when falling detection is on, and for either change when both are on. With neither enabled, the bit is never set.
- R7: Writing 1 to a bit of 0x48 clears that status bit, and writing 0 leaves it unchanged. When an edge is flagged on the same clock edge as its clear, the bit ends up set.
- R8: Status bits are set whether or not the pin's interrupt enable is on. With all interrupt enables at 0, `irq_o` stays low.
- R9: Interrupt enable reads and writes at 0x9c. `irq_o` is high exactly while some pin has both its status bit and its interrupt-enable bit at 1.
- R10: The write-only addresses (0x18, 0x24, 0x54, 0x60, 0x6c, 0x78, 0x84, 0x90) and any unmapped address read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, zero when not reading |
| pin_i | input | N_PINS | Pad input levels, asynchronous |
| pin_o | output | N_PINS | Pad output values |
| pin_oe_o | output | N_PINS | Pad output enables |
| irq_o | output | 1 | Combined level interrupt |

## Verification
Edge detection is driven from a table of enable and pin-transition patterns. The patterns cover pins split between rising-only and falling-only detection under a full rise and a full fall, a mixed toggle pattern with both enables on, a half-word swap with partial rising enables, and a transition with detection fully off. Together these show that the polarities are not swapped, that both-edge mode catches every toggle, and that unchanged pins stay quiet. Directed cases check the level read one and two cycles after a pin change to confirm the synchroniser depth. They also check an edge landing on the same edge as its clear, that a zero write to status has no effect, and the interrupt gating before and after its enable is written.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_LEVEL    = 8'h00;
  localparam logic [7:0] OFS_DIR      = 8'h0c;
  localparam logic [7:0] OFS_OUT_SET  = 8'h18;
  localparam logic [7:0] OFS_OUT_CLR  = 8'h24;
  localparam logic [7:0] OFS_RISE     = 8'h30;
  localparam logic [7:0] OFS_FALL     = 8'h3c;
  localparam logic [7:0] OFS_STATUS   = 8'h48;
  localparam logic [7:0] OFS_DIR_SET  = 8'h54;
  localparam logic [7:0] OFS_DIR_CLR  = 8'h60;
  localparam logic [7:0] OFS_RISE_SET = 8'h6c;
  localparam logic [7:0] OFS_RISE_CLR = 8'h78;
  localparam logic [7:0] OFS_FALL_SET = 8'h84;
  localparam logic [7:0] OFS_FALL_CLR = 8'h90;
  localparam logic [7:0] OFS_IRQ_EN   = 8'h9c;

  // index of each set/clear-capable control field
  localparam int unsigned CTL_OUT  = 0;
  localparam int unsigned CTL_DIR  = 1;
  localparam int unsigned CTL_RISE = 2;
  localparam int unsigned CTL_FALL = 3;
  localparam int unsigned N_CTL    = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (wr_i)       q_d = data_i;
    else if (set_i) q_d = q_q | data_i;
    else if (clr_i) q_d = q_q & ~data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] hit_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, status_q;

  assign hit_o = (level_i & ~prev_q & rise_en_i) | (~level_i & prev_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= level_i;
      // a new edge overrides a clear in the same cycle
      status_q <= (status_q & ~clr_i) | hit_o;
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_en_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  input  logic [N_PINS-1:0]    pin_i,
  output logic [N_PINS-1:0]    pin_o,
  output logic [N_PINS-1:0]    pin_oe_o,
  output logic                 irq_o
);
  localparam int unsigned PAD_W = BUS_W - N_PINS;

  logic                         wr, rd;
  logic [N_PINS-1:0]            wd;
  logic [N_CTL-1:0]             ctl_wr, ctl_set, ctl_clr;
  logic [N_CTL-1:0][N_PINS-1:0] ctl_q;
  logic [N_PINS-1:0]            level, status_q, edge_hit, st_clr, irq_en_q;
  logic [N_PINS-1:0]            rd_val;

  assign wr = bus_en_i & bus_we_i;
  assign rd = bus_en_i & ~bus_we_i;
  assign wd = bus_wdata_i[N_PINS-1:0];

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    ctl_wr  = '0;
    ctl_set = '0;
    ctl_clr = '0;
    ctl_set[CTL_OUT]  = wr & at(bus_addr_i, OFS_OUT_SET);
    ctl_clr[CTL_OUT]  = wr & at(bus_addr_i, OFS_OUT_CLR);
    ctl_wr[CTL_DIR]   = wr & at(bus_addr_i, OFS_DIR);
    ctl_set[CTL_DIR]  = wr & at(bus_addr_i, OFS_DIR_SET);
    ctl_clr[CTL_DIR]  = wr & at(bus_addr_i, OFS_DIR_CLR);
    ctl_wr[CTL_RISE]  = wr & at(bus_addr_i, OFS_RISE);
    ctl_set[CTL_RISE] = wr & at(bus_addr_i, OFS_RISE_SET);
    ctl_clr[CTL_RISE] = wr & at(bus_addr_i, OFS_RISE_CLR);
    ctl_wr[CTL_FALL]  = wr & at(bus_addr_i, OFS_FALL);
    ctl_set[CTL_FALL] = wr & at(bus_addr_i, OFS_FALL_SET);
    ctl_clr[CTL_FALL] = wr & at(bus_addr_i, OFS_FALL_CLR);
  end

  for (genvar k = 0; k < N_CTL; k++) begin : g_ctl
    gpio_alias_reg #(.W(N_PINS)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (ctl_wr[k]),
      .set_i  (ctl_set[k]),
      .clr_i  (ctl_clr[k]),
      .data_i (wd),
      .q_o    (ctl_q[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          irq_en_q <= '0;
    else if (wr && at(bus_addr_i, OFS_IRQ_EN)) irq_en_q <= wd;
  end

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (level)
  );

  assign st_clr = (wr && at(bus_addr_i, OFS_STATUS)) ? wd : '0;

  gpio_edge_unit #(.W(N_PINS)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .rise_en_i (ctl_q[CTL_RISE]),
    .fall_en_i (ctl_q[CTL_FALL]),
    .clr_i     (st_clr),
    .hit_o     (edge_hit),
    .status_o  (status_q)
  );

  always_comb begin
    rd_val = '0;
    if (rd) begin
      if      (at(bus_addr_i, OFS_LEVEL))  rd_val = level;
      else if (at(bus_addr_i, OFS_DIR))    rd_val = ctl_q[CTL_DIR];
      else if (at(bus_addr_i, OFS_RISE))   rd_val = ctl_q[CTL_RISE];
      else if (at(bus_addr_i, OFS_FALL))   rd_val = ctl_q[CTL_FALL];
      else if (at(bus_addr_i, OFS_STATUS)) rd_val = status_q;
      else if (at(bus_addr_i, OFS_IRQ_EN)) rd_val = irq_en_q;
    end
  end

  if (PAD_W > 0) begin : g_pad
    assign bus_rdata_o = {{PAD_W{1'b0}}, rd_val};
  end else begin : g_nopad
    assign bus_rdata_o = rd_val;
  end

  assign pin_o    = ctl_q[CTL_OUT];
  assign pin_oe_o = ctl_q[CTL_DIR];
  assign irq_o    = |(status_q & irq_en_q);
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_en_i,
  input logic                 bus_we_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [BUS_W-1:0]     bus_wdata_i,
  input logic [BUS_W-1:0]     bus_rdata_o,
  input logic [N_PINS-1:0]    pin_o,
  input logic [N_PINS-1:0]    pin_oe_o,
  input logic                 irq_o,
  input logic [N_PINS-1:0]    status_q,
  input logic [N_PINS-1:0]    edge_hit
);
  logic [N_PINS-1:0] wd;
  assign wd = bus_wdata_i[N_PINS-1:0];

  p_out_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_OUT_SET))
      |=> ((pin_o & $past(wd)) == $past(wd)));

  p_out_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_OUT_CLR))
      |=> ((pin_o & $past(wd)) == '0));

  p_dir_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_DIR))
      |=> (pin_oe_o == $past(wd)));

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && bus_addr_i == ADDR_W'(OFS_STATUS))
      |=> ((status_q & $past(wd) & ~$past(edge_hit)) == '0));

  p_edge_sets_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit != '0) |=> ((status_q & $past(edge_hit)) == $past(edge_hit)));

  p_irq_needs_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != '0));

  p_wo_reads_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !bus_we_i && (bus_addr_i == ADDR_W'(OFS_OUT_SET) ||
      bus_addr_i == ADDR_W'(OFS_DIR_CLR))) |-> (bus_rdata_o == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_en_i    (bus_en_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_o       (pin_o),
  .pin_oe_o    (pin_oe_o),
  .irq_o       (irq_o),
  .status_q    (status_q),
  .edge_hit    (edge_hit)
);

// File: tb/tb_gpio_edge_bank.sv
module tb_gpio_edge_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_en_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_edge_bank dut (
    .clk_i, .rst_ni, .bus_en_i, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .pin_i, .pin_o, .pin_oe_o, .irq_o
  );

  typedef struct packed {
    logic [31:0] rise;
    logic [31:0] fall;
    logic [31:0] from;
    logic [31:0] to;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'hFFFF0000, 32'h0000FFFF, 32'h00000000, 32'hFFFFFFFF, 32'hFFFF0000},
    '{32'hFFFF0000, 32'h0000FFFF, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00FF00FF, 32'h0F0F0F0F, 32'h0FF00FF0},
    '{32'hF0F0F0F0, 32'h00000000, 32'h0000FFFF, 32'hFFFF0000, 32'hF0F00000},
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    bus_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    idle(2);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 pin_oe_o", pin_oe_o, '0);
    check("R1 pin_o", pin_o, '0);
    check("R1 irq_o", {31'd0, irq_o}, '0);
    bus_read(8'h0c, rd); check("R1 dir", rd, '0);
    bus_read(8'h30, rd); check("R1 rise", rd, '0);
    bus_read(8'h3c, rd); check("R1 fall", rd, '0);
    bus_read(8'h48, rd); check("R1 status", rd, '0);
    bus_read(8'h9c, rd); check("R1 irq_en", rd, '0);

    // R6 R8 table of edge patterns, interrupt enables all off
    foreach (VECS[i]) begin
      bus_write(8'h30, VECS[i].rise);
      bus_write(8'h3c, VECS[i].fall);
      @(negedge clk_i);
      pin_i = VECS[i].from;
      idle(4);
      bus_write(8'h48, 32'hFFFFFFFF);
      pin_i = VECS[i].to;
      idle(3);
      #1;
      bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = 8'h48;
      #1 rd = bus_rdata_o;
      bus_en_i = 1'b0;
      check($sformatf("R6 vector %0d status", i), rd, VECS[i].exp);
      check($sformatf("R8 vector %0d irq low", i), {31'd0, irq_o}, '0);
    end

    // R3 output set/clear
    bus_write(8'h18, 32'hA5A5A5A5);
    check("R3 set", pin_o, 32'hA5A5A5A5);
    bus_write(8'h24, 32'h0000FFFF);
    check("R3 clear", pin_o, 32'hA5A50000);
    bus_write(8'h18, 32'h00000000);
    check("R3 zero set", pin_o, 32'hA5A50000);

    // R4 direction
    bus_write(8'h0c, 32'h12345678);
    check("R4 direct", pin_oe_o, 32'h12345678);
    bus_write(8'h54, 32'h80000001);
    bus_read(8'h0c, rd); check("R4 set alias", rd, 32'h92345679);
    bus_write(8'h60, 32'h12000000);
    bus_read(8'h0c, rd); check("R4 clear alias", rd, 32'h80345679);
    check("R4 pin_oe_o", pin_oe_o, 32'h80345679);

    // R5 edge-enable aliases
    bus_write(8'h30, 32'h0000000F);
    bus_write(8'h6c, 32'h000000F0);
    bus_write(8'h78, 32'h00000003);
    bus_read(8'h30, rd); check("R5 rise aliases", rd, 32'h000000FC);
    bus_write(8'h3c, 32'hF0000000);
    bus_write(8'h84, 32'h0F000000);
    bus_write(8'h90, 32'h30000000);
    bus_read(8'h3c, rd); check("R5 fall aliases", rd, 32'hCF000000);

    // R10 write-only and unmapped reads
    bus_read(8'h18, rd); check("R10 out set reads 0", rd, '0);
    bus_read(8'h24, rd); check("R10 out clr reads 0", rd, '0);
    bus_read(8'h54, rd); check("R10 dir set reads 0", rd, '0);
    bus_read(8'h6c, rd); check("R10 rise set reads 0", rd, '0);
    bus_read(8'h90, rd); check("R10 fall clr reads 0", rd, '0);
    bus_read(8'h04, rd); check("R10 unmapped 04", rd, '0);
    bus_read(8'ha0, rd); check("R10 unmapped a0", rd, '0);

    // R2 level read latency, independent of direction (some pins are outputs)
    @(negedge clk_i);
    pin_i = 32'hCAFE1234;
    bus_read(8'h00, rd); check("R2 one cycle old", rd, 32'hFFFFFFFF);
    bus_read(8'h00, rd); check("R2 two cycles new", rd, 32'hCAFE1234);

    // R7 R9 status and interrupt gating
    bus_write(8'h30, 32'h00000003);
    bus_write(8'h3c, 32'h00000000);
    @(negedge clk_i);
    pin_i = 32'h0;
    idle(4);
    bus_write(8'h48, 32'hFFFFFFFF);
    @(negedge clk_i);
    pin_i = 32'h00000002;
    idle(4);
    bus_read(8'h48, rd); check("R8 status w/o enable", rd, 32'h00000002);
    check("R8 irq low", {31'd0, irq_o}, '0);
    bus_write(8'h9c, 32'h00000001);
    check("R9 irq masked pin", {31'd0, irq_o}, '0);
    bus_write(8'h9c, 32'h00000002);
    check("R9 irq enabled", {31'd0, irq_o}, 32'd1);
    bus_read(8'h9c, rd); check("R9 irq_en read", rd, 32'h00000002);
    bus_write(8'h48, 32'h00000000);
    bus_read(8'h48, rd); check("R7 zero write keeps", rd, 32'h00000002);
    bus_write(8'h48, 32'h00000002);
    bus_read(8'h48, rd); check("R7 w1c clears", rd, '0);
    check("R9 irq drops", {31'd0, irq_o}, '0);

    // R7 collision: bit0 edge lands on the clear edge, bit1 plain clear
    pin_i = 32'h0;
    idle(4);
    bus_write(8'h48, 32'hFFFFFFFF);
    @(negedge clk_i);
    pin_i = 32'h00000002;
    idle(4);
    pin_i = 32'h00000003;
    @(negedge clk_i);
    bus_write(8'h48, 32'h00000003);
    bus_read(8'h48, rd); check("R7 edge beats clear", rd, 32'h00000001);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule